// File: doc/BRIEF.md
# Descriptor-Driven Data Transfer Controller

This block moves one data item per activation between two locations on a simple memory bus. The parameters for each move are kept as a six-word descriptor in a small internal RAM, not in flip-flops. A vector table at the bottom of that RAM maps each vector number to the base address of its descriptor. There are two ways to start a move. A peripheral can raise a request line, and this only counts while that source's enable bit is set. Software can instead set a start bit and supply a vector number.

For each activation the block does the following in order:
- reads the vector entry;
- fetches the descriptor;
- performs one bus read from the source address and one bus write to the destination address;
- steps the addresses and the transfer count;
- writes the three changed words back to the RAM.

The count reaching zero and a per-descriptor interrupt-select bit together decide whether a CPU interrupt is pulsed. They also decide whether the enable bit or start bit is cleared or kept. Requests that arrive while the engine is busy are held per source and served in a fixed order.

Only the plain one-item-per-activation mode is supported, with byte or 16-bit word size. The chain bit, the alternate mode encodings and the second count word are stored in the descriptor but have no effect.

Top module: `xfer_ctrl`

## Requirements
- R1: After reset, busy_o, irq_o and mem_req_o are low, en_o is all zeros and sw_bit_o is 0.
- R2: RAM word v (v < NUM_VEC) holds the descriptor base for vector v. Hardware source k uses vector k. The descriptor words at offsets from the base are:
  - +0: mode word. Bits [1:0] are the source address mode, bits [3:2] the destination address mode, and bit 6 the size (0 = byte, 1 = word).
  - +1: control word. Bit 1 is the interrupt-select bit.
  - +2: source address.
  - +3: destination address.
  - +4: count.
  - +5: ignored and never written.
- R3: Address mode 10 increments and mode 11 decrements the address after each transfer. Modes 00 and 01 keep it fixed. The step is 1 for byte transfers and 2 for word transfers. The updated addresses are written back to offsets +2 and +3.
- R4: A byte transfer drives mem_size_o=0 and writes the low 8 bits of the read data with the upper bits zero. A word transfer drives mem_size_o=1 and moves all 16 bits.
- R5: The count at +4 is decremented by one per transfer and written back. A loaded count of 0 becomes 0xFFFF after the first transfer, so it stands for 65536 transfers.
- R6: A pulse on req_i[k] is accepted only while en_o[k]=1. Otherwise it causes no bus activity.
- R7: For a hardware source with interrupt-select 0, no interrupt is raised until the count reaches zero. At that point en_o[k] is cleared and irq_o pulses for one cycle with irq_vec_o=k.
- R8: For a hardware source with interrupt-select 1, irq_o pulses after every transfer, and en_o[k] stays set until the count reaches zero.
- R9: Writing sw_bit_i=1 with sw_bit_o=0 sets the start bit and starts vector sw_vec_i. After the transfer:
  - with interrupt-select 0 and a nonzero count, the start bit is cleared and no interrupt is raised;
  - with interrupt-select 1, or a count of zero, the start bit stays 1 and irq_o pulses with irq_vec_o set to that vector.
- R10: Writing sw_bit_i=1 while sw_bit_o=1 is ignored and starts nothing. Writing sw_bit_i=0 clears the start bit.
- R11: Pending requests are queued, including those that arrive while busy. They are served lowest hardware source first, and a software start is served after all pending hardware sources.
- R12: busy_o is high from the vector read through the write-back. Each activation makes exactly one bus read followed by one bus write. mem_req_o is asserted only while busy_o is high, and the address is held until mem_ack_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | NUM_SRC | Per-source transfer request pulses |
| en_wr_i | input | 1 | Load the source enable register |
| en_wdata_i | input | NUM_SRC | New source enable value |
| en_o | output | NUM_SRC | Current source enables |
| sw_wr_i | input | 1 | Software start-bit write strobe |
| sw_bit_i | input | 1 | Start-bit value written |
| sw_vec_i | input | VEC_W | Vector number for a software start |
| sw_bit_o | output | 1 | Current start bit |
| cfg_we_i | input | 1 | Descriptor RAM write enable |
| cfg_addr_i | input | RAM_AW | Descriptor RAM write address |
| cfg_wdata_i | input | DW | Descriptor RAM write data |
| cfg_raddr_i | input | RAM_AW | Descriptor RAM read address |
| cfg_rdata_o | output | DW | Descriptor RAM read data (combinational) |
| mem_req_o | output | 1 | Bus request, held until acknowledged |
| mem_we_o | output | 1 | Bus write (1) or read (0) |
| mem_size_o | output | 1 | 0 byte, 1 word |
| mem_addr_o | output | DW | Bus address |
| mem_wdata_o | output | DW | Bus write data |
| mem_rdata_i | input | DW | Bus read data, valid with mem_ack_i |
| mem_ack_i | input | 1 | Bus access complete |
| busy_o | output | 1 | Activation in progress |
| irq_o | output | 1 | One-cycle CPU interrupt pulse |
| irq_vec_o | output | VEC_W | Vector of the activation raising irq_o |

## Verification
The embedded properties check the following on every cycle:
- the bus address and direction stay stable until the acknowledge;
- the interrupt is a single-cycle pulse;
- byte writes carry zero upper bits;
- the count drops by exactly one per completed write;
- grants honour the lowest-index rule;
- an enable is dropped when its count reaches zero;
- a software start write made while the start bit is set leaves the latched vector untouched.

Only the bench scenarios can show the rest:
- that the vector table really redirects to the right descriptor;
- that the written-back addresses and the 0-means-65536 count land in the RAM;
- the exact order in which queued and software requests are served;
- the interrupt and enable outcomes over a whole sequence of transfers.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_VEC,
    ST_FETCH,
    ST_RD,
    ST_WR,
    ST_WB,
    ST_FIN
  } eng_state_e;

  // descriptor word offsets from base
  localparam int OFS_MODE = 0;
  localparam int OFS_CTRL = 1;
  localparam int OFS_SRC  = 2;
  localparam int OFS_DST  = 3;
  localparam int OFS_CNT  = 4;

  // mode word fields
  localparam int MODE_SRC_LSB = 0;
  localparam int MODE_DST_LSB = 2;
  localparam int MODE_SIZE    = 6;
  // control word fields
  localparam int CTRL_IRQ_SEL = 1;

  localparam logic [1:0] AM_INC = 2'b10;
  localparam logic [1:0] AM_DEC = 2'b11;

endpackage

// File: rtl/xfer_desc_ram.sv
module xfer_desc_ram #(
  parameter int AW = 6,
  parameter int DW = 16,
  localparam int Depth = 1 << AW
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  output logic [DW-1:0] rdata_a_o,
  input  logic [AW-1:0] raddr_b_i,
  output logic [DW-1:0] rdata_b_o
);

  logic [DW-1:0] mem_q [Depth];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_a_o = mem_q[raddr_a_i];
  assign rdata_b_o = mem_q[raddr_b_i];

endmodule

// File: rtl/xfer_req_arb.sv
module xfer_req_arb #(
  parameter int NUM_SRC = 4,
  parameter int NUM_VEC = 8,
  localparam int VecW = $clog2(NUM_VEC),
  localparam int SrcW = $clog2(NUM_SRC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic               en_wr_i,
  input  logic [NUM_SRC-1:0] en_wdata_i,
  output logic [NUM_SRC-1:0] en_o,
  input  logic               sw_wr_i,
  input  logic               sw_bit_i,
  input  logic [VecW-1:0]    sw_vec_i,
  output logic               sw_bit_o,
  input  logic               take_i,
  input  logic               fin_i,
  input  logic               fin_irq_i,
  input  logic               fin_zero_i,
  output logic               grant_vld_o,
  output logic [VecW-1:0]    grant_vec_o
);

  logic [NUM_SRC-1:0] en_q, pend_q, hw_act;
  logic [SrcW-1:0]    sel_idx, cur_src_q;
  logic               hw_any, grant_sw, cur_sw_q;
  logic               sw_bit_q, sw_pend_q;
  logic [VecW-1:0]    sw_vec_q;

  assign hw_act = pend_q & en_q;
  assign hw_any = |hw_act;

  // lowest index wins
  always_comb begin
    sel_idx = '0;
    for (int k = NUM_SRC - 1; k >= 0; k--) begin
      if (hw_act[k]) sel_idx = SrcW'(k);
    end
  end

  assign grant_sw    = !hw_any && sw_pend_q;
  assign grant_vld_o = hw_any || sw_pend_q;
  assign grant_vec_o = grant_sw ? sw_vec_q : VecW'(sel_idx);

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    logic take_k, clr_k, en_n, en_r, pend_r;
    assign take_k = take_i && !grant_sw && (sel_idx == SrcW'(k));
    assign clr_k  = fin_i && !cur_sw_q && fin_zero_i && (cur_src_q == SrcW'(k));
    assign en_n   = en_wr_i ? en_wdata_i[k] : (en_r && !clr_k);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_r   <= 1'b0;
        pend_r <= 1'b0;
      end else begin
        en_r   <= en_n;
        pend_r <= ((pend_r && !take_k) || req_i[k]) && en_n;
      end
    end

    assign en_q[k]   = en_r;
    assign pend_q[k] = pend_r;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_bit_q  <= 1'b0;
      sw_pend_q <= 1'b0;
      sw_vec_q  <= '0;
    end else begin
      if (take_i && grant_sw) sw_pend_q <= 1'b0;
      if (fin_i && cur_sw_q && !fin_irq_i) sw_bit_q <= 1'b0;
      if (sw_wr_i) begin
        if (!sw_bit_i) begin
          sw_bit_q  <= 1'b0;
          sw_pend_q <= 1'b0;
        end else if (!sw_bit_q) begin
          sw_bit_q  <= 1'b1;
          sw_pend_q <= 1'b1;
          sw_vec_q  <= sw_vec_i;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_sw_q  <= 1'b0;
      cur_src_q <= '0;
    end else if (take_i) begin
      cur_sw_q  <= grant_sw;
      cur_src_q <= sel_idx;
    end
  end

  assign en_o     = en_q;
  assign sw_bit_o = sw_bit_q;

  p_take_valid_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> grant_vld_o);

  p_prio_low_first_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_vld_o && hw_any) |->
      ((hw_act & ((NUM_SRC'(1) << sel_idx) - NUM_SRC'(1))) == '0) && hw_act[sel_idx]);

  p_en_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin_i && !cur_sw_q && fin_zero_i && !en_wr_i) |=> !en_q[$past(cur_src_q)]);

  p_sw_ignore_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_wr_i && sw_bit_i && sw_bit_q && !fin_i) |=> (sw_bit_q && $stable(sw_vec_q)));

  p_sw_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin_i && cur_sw_q && fin_irq_i && !sw_wr_i) |=> sw_bit_q);

endmodule

// File: rtl/xfer_engine.sv
module xfer_engine
  import xfer_pkg::*;
#(
  parameter int NUM_VEC = 8,
  parameter int RAM_AW  = 6,
  parameter int DW      = 16,
  localparam int VecW   = $clog2(NUM_VEC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              grant_vld_i,
  input  logic [VecW-1:0]   grant_vec_i,
  output logic              take_o,
  output logic [RAM_AW-1:0] ram_raddr_o,
  input  logic [DW-1:0]     ram_rdata_i,
  output logic              ram_we_o,
  output logic [RAM_AW-1:0] ram_waddr_o,
  output logic [DW-1:0]     ram_wdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic              mem_size_o,
  output logic [DW-1:0]     mem_addr_o,
  output logic [DW-1:0]     mem_wdata_o,
  input  logic [DW-1:0]     mem_rdata_i,
  input  logic              mem_ack_i,
  output logic              busy_o,
  output logic              fin_o,
  output logic              fin_irq_o,
  output logic              fin_zero_o,
  output logic              irq_o,
  output logic [VecW-1:0]   irq_vec_o
);

  eng_state_e        st_q;
  logic [VecW-1:0]   vec_q;
  logic [RAM_AW-1:0] base_q;
  logic [2:0]        idx_q;
  logic [1:0]        src_mode_q, dst_mode_q;
  logic              size_q, sel_q;
  logic [DW-1:0]     sar_q, dar_q, cnt_q, data_q;
  logic              cnt_zero;

  function automatic logic [DW-1:0] step_addr(input logic [DW-1:0] a,
                                               input logic [1:0] m,
                                               input logic sz);
    logic [DW-1:0] d;
    d = sz ? DW'(2) : DW'(1);
    case (m)
      AM_INC:  return a + d;
      AM_DEC:  return a - d;
      default: return a;
    endcase
  endfunction

  assign cnt_zero = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      vec_q      <= '0;
      base_q     <= '0;
      idx_q      <= '0;
      src_mode_q <= '0;
      dst_mode_q <= '0;
      size_q     <= 1'b0;
      sel_q      <= 1'b0;
      sar_q      <= '0;
      dar_q      <= '0;
      cnt_q      <= '0;
      data_q     <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (grant_vld_i) begin
          vec_q <= grant_vec_i;
          st_q  <= ST_VEC;
        end
        ST_VEC: begin
          base_q <= ram_rdata_i[RAM_AW-1:0];
          idx_q  <= '0;
          st_q   <= ST_FETCH;
        end
        ST_FETCH: begin
          case (idx_q)
            3'(OFS_MODE): begin
              src_mode_q <= ram_rdata_i[MODE_SRC_LSB +: 2];
              dst_mode_q <= ram_rdata_i[MODE_DST_LSB +: 2];
              size_q     <= ram_rdata_i[MODE_SIZE];
            end
            3'(OFS_CTRL): sel_q <= ram_rdata_i[CTRL_IRQ_SEL];
            3'(OFS_SRC):  sar_q <= ram_rdata_i;
            3'(OFS_DST):  dar_q <= ram_rdata_i;
            default:      cnt_q <= ram_rdata_i;
          endcase
          if (idx_q == 3'(OFS_CNT)) begin
            idx_q <= '0;
            st_q  <= ST_RD;
          end else begin
            idx_q <= idx_q + 3'd1;
          end
        end
        ST_RD: if (mem_ack_i) begin
          data_q <= size_q ? mem_rdata_i : DW'(mem_rdata_i[7:0]);
          st_q   <= ST_WR;
        end
        ST_WR: if (mem_ack_i) begin
          sar_q <= step_addr(sar_q, src_mode_q, size_q);
          dar_q <= step_addr(dar_q, dst_mode_q, size_q);
          cnt_q <= cnt_q - DW'(1);
          idx_q <= '0;
          st_q  <= ST_WB;
        end
        ST_WB: begin
          if (idx_q == 3'd2) st_q <= ST_FIN;
          idx_q <= idx_q + 3'd1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ram_raddr_o = base_q + RAM_AW'(idx_q);
    if (st_q == ST_VEC) ram_raddr_o = RAM_AW'(vec_q);
  end

  assign ram_we_o    = (st_q == ST_WB);
  assign ram_waddr_o = base_q + RAM_AW'(OFS_SRC) + RAM_AW'(idx_q);
  always_comb begin
    case (idx_q)
      3'd0:    ram_wdata_o = sar_q;
      3'd1:    ram_wdata_o = dar_q;
      default: ram_wdata_o = cnt_q;
    endcase
  end

  assign take_o      = (st_q == ST_IDLE) && grant_vld_i;
  assign mem_req_o   = (st_q == ST_RD) || (st_q == ST_WR);
  assign mem_we_o    = (st_q == ST_WR);
  assign mem_size_o  = size_q;
  assign mem_addr_o  = (st_q == ST_WR) ? dar_q : sar_q;
  assign mem_wdata_o = data_q;
  assign busy_o      = (st_q != ST_IDLE);
  assign fin_o       = (st_q == ST_FIN);
  assign fin_zero_o  = fin_o && cnt_zero;
  assign irq_o       = fin_o && (cnt_zero || sel_q);
  assign fin_irq_o   = irq_o;
  assign irq_vec_o   = vec_q;

  p_bus_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=>
      (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

  p_irq_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  p_byte_upper_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && !mem_size_o) |-> (mem_wdata_o[DW-1:8] == '0));

  p_cnt_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WR && mem_ack_i) |=> (cnt_q == $past(cnt_q) - DW'(1)));

endmodule

// File: rtl/xfer_ctrl.sv
module xfer_ctrl #(
  parameter int NUM_SRC = 4,
  parameter int NUM_VEC = 8,
  parameter int RAM_AW  = 6,
  parameter int DW      = 16,
  localparam int VecW   = $clog2(NUM_VEC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic               en_wr_i,
  input  logic [NUM_SRC-1:0] en_wdata_i,
  output logic [NUM_SRC-1:0] en_o,
  input  logic               sw_wr_i,
  input  logic               sw_bit_i,
  input  logic [VecW-1:0]    sw_vec_i,
  output logic               sw_bit_o,
  input  logic               cfg_we_i,
  input  logic [RAM_AW-1:0]  cfg_addr_i,
  input  logic [DW-1:0]      cfg_wdata_i,
  input  logic [RAM_AW-1:0]  cfg_raddr_i,
  output logic [DW-1:0]      cfg_rdata_o,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic               mem_size_o,
  output logic [DW-1:0]      mem_addr_o,
  output logic [DW-1:0]      mem_wdata_o,
  input  logic [DW-1:0]      mem_rdata_i,
  input  logic               mem_ack_i,
  output logic               busy_o,
  output logic               irq_o,
  output logic [VecW-1:0]    irq_vec_o
);

  logic              take, fin, fin_irq, fin_zero, grant_vld;
  logic [VecW-1:0]   grant_vec;
  logic [RAM_AW-1:0] eng_raddr, eng_waddr, ram_waddr;
  logic [DW-1:0]     eng_rdata, eng_wdata, ram_wdata;
  logic              eng_we, ram_we;

  // engine write-back has the port; a config write in that cycle is dropped
  assign ram_we    = eng_we || cfg_we_i;
  assign ram_waddr = eng_we ? eng_waddr : cfg_addr_i;
  assign ram_wdata = eng_we ? eng_wdata : cfg_wdata_i;

  xfer_desc_ram #(.AW(RAM_AW), .DW(DW)) u_ram (
    .clk_i     (clk_i),
    .we_i      (ram_we),
    .waddr_i   (ram_waddr),
    .wdata_i   (ram_wdata),
    .raddr_a_i (eng_raddr),
    .rdata_a_o (eng_rdata),
    .raddr_b_i (cfg_raddr_i),
    .rdata_b_o (cfg_rdata_o)
  );

  xfer_req_arb #(.NUM_SRC(NUM_SRC), .NUM_VEC(NUM_VEC)) u_arb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .en_wr_i     (en_wr_i),
    .en_wdata_i  (en_wdata_i),
    .en_o        (en_o),
    .sw_wr_i     (sw_wr_i),
    .sw_bit_i    (sw_bit_i),
    .sw_vec_i    (sw_vec_i),
    .sw_bit_o    (sw_bit_o),
    .take_i      (take),
    .fin_i       (fin),
    .fin_irq_i   (fin_irq),
    .fin_zero_i  (fin_zero),
    .grant_vld_o (grant_vld),
    .grant_vec_o (grant_vec)
  );

  xfer_engine #(.NUM_VEC(NUM_VEC), .RAM_AW(RAM_AW), .DW(DW)) u_eng (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .grant_vld_i (grant_vld),
    .grant_vec_i (grant_vec),
    .take_o      (take),
    .ram_raddr_o (eng_raddr),
    .ram_rdata_i (eng_rdata),
    .ram_we_o    (eng_we),
    .ram_waddr_o (eng_waddr),
    .ram_wdata_o (eng_wdata),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_size_o  (mem_size_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_rdata_i (mem_rdata_i),
    .mem_ack_i   (mem_ack_i),
    .busy_o      (busy_o),
    .fin_o       (fin),
    .fin_irq_o   (fin_irq),
    .fin_zero_o  (fin_zero),
    .irq_o       (irq_o),
    .irq_vec_o   (irq_vec_o)
  );

  p_req_in_busy_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o);

endmodule

// File: tb/xfer_ctrl_bench.sv
`timescale 1ns/1ps
module xfer_ctrl_bench;

  localparam int NS = 4, NV = 8, AW = 6, DW = 16, VW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NS-1:0] req = '0, en_wdata = '0, en;
  logic en_wr = 1'b0, sw_wr = 1'b0, sw_bit = 1'b0, sw_bit_q;
  logic [VW-1:0] sw_vec = '0, irq_vec;
  logic cfg_we = 1'b0;
  logic [AW-1:0] cfg_addr = '0, cfg_raddr = '0;
  logic [DW-1:0] cfg_wdata = '0, cfg_rdata;
  logic mem_req, mem_we, mem_size, mem_ack = 1'b0, busy, irq;
  logic [DW-1:0] mem_addr, mem_wdata, mem_rdata = '0;

  always #2 clk = ~clk;

  xfer_ctrl #(.NUM_SRC(NS), .NUM_VEC(NV), .RAM_AW(AW), .DW(DW)) u_xfer_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .en_wr_i(en_wr), .en_wdata_i(en_wdata),
    .en_o(en), .sw_wr_i(sw_wr), .sw_bit_i(sw_bit), .sw_vec_i(sw_vec), .sw_bit_o(sw_bit_q),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .cfg_raddr_i(cfg_raddr), .cfg_rdata_o(cfg_rdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_size_o(mem_size), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack),
    .busy_o(busy), .irq_o(irq), .irq_vec_o(irq_vec));

  int checks = 0, fails = 0;
  int wr_cnt = 0, irq_cnt = 0, req_no_busy = 0, busy_cycles = 0;
  int rd_cnt = 0;
  logic [VW-1:0] last_irq_vec = '0;
  logic [DW-1:0] bmem [256];
  logic [DW-1:0] wr_log [16];
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // bus responder and monitors
  initial begin
    forever begin
      @(negedge clk);
      if (busy) busy_cycles++;
      if (irq) begin irq_cnt++; last_irq_vec = irq_vec; end
      if (mem_req && !busy) req_no_busy++;
      if (mem_req && !mem_ack) begin
        mem_ack = 1'b1;
        if (mem_we) begin
          bmem[mem_addr[7:0]] = mem_wdata;
          wr_log[wr_cnt % 16] = mem_addr;
          wr_cnt++;
        end else begin
          mem_rdata = bmem[mem_addr[7:0]];
          rd_cnt++;
        end
      end else begin
        mem_ack = 1'b0;
      end
    end
  end

  task automatic cfg_wr(input int a, input logic [DW-1:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = AW'(a); cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic cfg_rd(input int a, output logic [DW-1:0] d);
    @(negedge clk); cfg_raddr = AW'(a); #1 d = cfg_rdata;
  endtask

  task automatic set_desc(input int b, input logic [DW-1:0] mode, input logic [DW-1:0] ctl,
                          input logic [DW-1:0] s, input logic [DW-1:0] d, input logic [DW-1:0] c);
    cfg_wr(b, mode); cfg_wr(b + 1, ctl); cfg_wr(b + 2, s);
    cfg_wr(b + 3, d); cfg_wr(b + 4, c); cfg_wr(b + 5, 16'h5A5A);
  endtask

  task automatic set_en(input logic [NS-1:0] v);
    @(negedge clk); en_wr = 1'b1; en_wdata = v;
    @(negedge clk); en_wr = 1'b0;
  endtask

  task automatic pulse_req(input logic [NS-1:0] m);
    @(negedge clk); req = m;
    @(negedge clk); req = '0;
  endtask

  task automatic sw_write(input logic b, input logic [VW-1:0] v);
    @(negedge clk); sw_wr = 1'b1; sw_bit = b; sw_vec = v;
    @(negedge clk); sw_wr = 1'b0;
  endtask

  task automatic wait_quiet();
    int q = 0;
    int t = 0;
    while (q < 6 && t < 2000) begin
      @(negedge clk);
      t++;
      if (busy || mem_req) q = 0; else q++;
    end
    if (t >= 2000) begin checks++; fails++; $display("FAIL R12 engine stuck busy act=1 exp=0"); end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] rv;
    int w0, i0, b0;
    for (int i = 0; i < 256; i++) bmem[i] = 16'(i * 3 + 16'h0100);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", 32'(busy), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 mem_req", 32'(mem_req), 0);
    chk("R1 en", 32'(en), 0);
    chk("R1 sw_bit", 32'(sw_bit_q), 0);

    // R2 vector table
    cfg_wr(0, 16'd8); cfg_wr(1, 16'd14); cfg_wr(2, 16'd20); cfg_wr(3, 16'd26); cfg_wr(5, 16'd32);

    // src0: byte, fixed source, incrementing destination, count 3, select 0
    set_desc(8, 16'h0008, 16'h0000, 16'h0010, 16'h0040, 16'd3);
    set_en(4'b0001);
    w0 = wr_cnt; i0 = irq_cnt;
    for (int k = 0; k < 3; k++) begin
      bmem[16'h10] = 16'h1200 | 16'(8'hA0 + k);
      pulse_req(4'b0001);
      wait_quiet();
      chk("R4 byte data low only", 32'(bmem[8'h40 + k]), 32'(8'hA0 + k));
      if (k < 2) begin
        chk("R7 no irq before zero", 32'(irq_cnt - i0), 0);
        chk("R7 enable kept", 32'(en[0]), 1);
      end
    end
    chk("R12 one write per activation", 32'(wr_cnt - w0), 3);
    chk("R7 irq at zero", 32'(irq_cnt - i0), 1);
    chk("R7 irq vector", 32'(last_irq_vec), 0);
    chk("R7 enable cleared", 32'(en[0]), 0);
    cfg_rd(10, rv); chk("R3 fixed source written back", 32'(rv), 32'h10);
    cfg_rd(11, rv); chk("R3 byte dest step", 32'(rv), 32'h43);
    cfg_rd(12, rv); chk("R5 count written back", 32'(rv), 0);
    cfg_rd(13, rv); chk("R2 word +5 untouched", 32'(rv), 32'h5A5A);

    // R6 request while disabled
    w0 = wr_cnt; b0 = busy_cycles;
    pulse_req(4'b0001);
    wait_quiet();
    chk("R6 disabled no write", 32'(wr_cnt - w0), 0);
    chk("R6 disabled never busy", 32'(busy_cycles - b0), 0);

    // src1: word, src increment, dst decrement, count 2, select 1
    set_desc(14, 16'h004E, 16'h0002, 16'h0080, 16'h00C8, 16'd2);
    bmem[8'h80] = 16'h1234; bmem[8'h82] = 16'hBEEF;
    set_en(4'b0010);
    i0 = irq_cnt;
    pulse_req(4'b0010); wait_quiet();
    chk("R4 word data", 32'(bmem[8'hC8]), 32'h1234);
    chk("R8 irq each transfer", 32'(irq_cnt - i0), 1);
    chk("R8 irq vector", 32'(last_irq_vec), 1);
    chk("R8 enable kept", 32'(en[1]), 1);
    pulse_req(4'b0010); wait_quiet();
    chk("R3 word decrement target", 32'(bmem[8'hC6]), 32'hBEEF);
    chk("R8 second irq", 32'(irq_cnt - i0), 2);
    chk("R8 enable cleared at zero", 32'(en[1]), 0);
    cfg_rd(16, rv); chk("R3 word increment", 32'(rv), 32'h84);
    cfg_rd(17, rv); chk("R3 word decrement", 32'(rv), 32'hC4);

    // R5 count 0 means 65536
    set_desc(20, 16'h0000, 16'h0000, 16'h0011, 16'h0050, 16'd0);
    set_en(4'b0100);
    i0 = irq_cnt;
    pulse_req(4'b0100); wait_quiet();
    cfg_rd(24, rv); chk("R5 zero load wraps", 32'(rv), 32'hFFFF);
    cfg_rd(23, rv); chk("R3 fixed dest", 32'(rv), 32'h50);
    chk("R5 no irq after wrap", 32'(irq_cnt - i0), 0);
    chk("R5 enable kept after wrap", 32'(en[2]), 1);
    set_en(4'b0000);

    // software start, vector 5
    set_desc(32, 16'h0008, 16'h0000, 16'h0012, 16'h0060, 16'd4);
    bmem[8'h12] = 16'h3377;
    i0 = irq_cnt;
    sw_write(1'b1, 3'd5); wait_quiet();
    chk("R9 sw transfer", 32'(bmem[8'h60]), 32'h77);
    chk("R9 start bit cleared", 32'(sw_bit_q), 0);
    chk("R9 no irq", 32'(irq_cnt - i0), 0);
    cfg_wr(36, 16'd1);
    sw_write(1'b1, 3'd5); wait_quiet();
    chk("R9 sw second transfer", 32'(bmem[8'h61]), 32'h77);
    chk("R9 start bit held at zero", 32'(sw_bit_q), 1);
    chk("R9 irq at zero", 32'(irq_cnt - i0), 1);
    chk("R9 irq vector", 32'(last_irq_vec), 5);
    w0 = wr_cnt;
    sw_write(1'b1, 3'd5); wait_quiet();
    chk("R10 start ignored while set", 32'(wr_cnt - w0), 0);
    chk("R10 bit still set", 32'(sw_bit_q), 1);
    sw_write(1'b0, 3'd0);
    chk("R10 write 0 clears", 32'(sw_bit_q), 0);
    cfg_wr(33, 16'h0002); cfg_wr(36, 16'd10);
    i0 = irq_cnt;
    sw_write(1'b1, 3'd5); wait_quiet();
    chk("R9 select holds start bit", 32'(sw_bit_q), 1);
    chk("R9 select raises irq", 32'(irq_cnt - i0), 1);
    sw_write(1'b0, 3'd0);

    // R11 priority and queueing
    set_desc(14, 16'h0008, 16'h0000, 16'h0013, 16'h00D0, 16'd10);
    set_desc(20, 16'h0008, 16'h0000, 16'h0013, 16'h00E0, 16'd10);
    set_desc(26, 16'h0008, 16'h0000, 16'h0013, 16'h00F0, 16'd10);
    set_desc(32, 16'h0008, 16'h0000, 16'h0013, 16'h00A0, 16'd10);
    set_en(4'b1110);
    w0 = wr_cnt;
    @(negedge clk); req = 4'b1110; sw_wr = 1'b1; sw_bit = 1'b1; sw_vec = 3'd5;
    @(negedge clk); req = '0; sw_wr = 1'b0;
    wait_quiet();
    chk("R11 served count", 32'(wr_cnt - w0), 4);
    chk("R11 first src1", 32'(wr_log[(w0 + 0) % 16]), 32'hD0);
    chk("R11 second src2", 32'(wr_log[(w0 + 1) % 16]), 32'hE0);
    chk("R11 third src3", 32'(wr_log[(w0 + 2) % 16]), 32'hF0);
    chk("R11 software last", 32'(wr_log[(w0 + 3) % 16]), 32'hA0);
    sw_write(1'b0, 3'd0);
    w0 = wr_cnt;
    pulse_req(4'b1000);
    while (!busy) @(negedge clk);
    pulse_req(4'b0010);
    wait_quiet();
    chk("R11 queued during busy first", 32'(wr_log[(w0 + 0) % 16]), 32'hF1);
    chk("R11 queued during busy second", 32'(wr_log[(w0 + 1) % 16]), 32'hD1);
    chk("R12 reads match writes", 32'(rd_cnt), 32'(wr_cnt));
    chk("R12 bus only while busy", 32'(req_no_busy), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule